// File: doc/BRIEF.md
# Pixel-Clock Video Timing Generator

This block produces horizontal sync, vertical sync and a data-enable strobe for a digital television output, and forms the 24-bit RGB pixel stream that goes with them. It keeps two counters. One is a line counter whose position 0 is the leading edge of horizontal sync. The other is a frame counter that counts pixel clocks, not lines, from the start of the frame. Every vertical quantity is therefore programmed already multiplied by the line length. Examples are the frame length, the vertical sync length and the display window's first and last pixel.

Software sets the timing through a plain register write port. Writes to timing fields land in a shadow copy. The running set takes that copy only at a frame boundary, or at any time while the generator is stopped. The run bit starts the generator at once from the stopped state. Clearing the run bit mid-frame has no effect until the frame ends. At that boundary the block still raises its frame pulse, so software can see that the stop has taken hold. Inside the display window the pixel input is passed through. If the source runs dry there and recovery is on, a programmed fill colour is sent in its place. Outside the window, within a running frame, the border colour is sent.

Top module: `tv_timing_gen`

## Requirements
- R1: Register map (word address on `reg_addr`). 0: line period in [15:0], hsync width in [31:16]. 1: frame period in pixel clocks. 2: vsync length in pixel clocks. 3: window first column in [15:0], last column in [31:16]. 4: window first frame pixel. 5: window last frame pixel. 6: hsync skew in [15:0]. 7: bit 0 makes hsync active-low, bit 1 makes vsync active-low. 8: border colour in [23:0]. 9: fill colour byte in [7:0], recovery enable in bit 8. 10: run bit in bit 0.
- R2: After reset, hsync, vsync, data-enable, frame pulse and RGB output are all 0. The fill colour resets to 0xFF and every other field resets to 0.
- R3: While running, hsync is active for line positions p with skew <= p < skew + width. The line position returns to 0 after period - 1 and at every frame start.
- R4: While running, vsync is active for frame positions below the vsync length. A frame lasts exactly the frame period in clocks.
- R5: Data-enable is high only while running and while both of these hold: first column <= line position <= last column, and first frame pixel <= frame position <= last frame pixel.
- R6: Each polarity bit takes effect from the write onward. While a bit is set, its sync idles high and is driven low when active.
- R7: While running and outside the window, the RGB output equals the border colour. While stopped it is 0.
- R8: Inside the window, RGB equals the pixel input when pixel-valid is high. When pixel-valid is low and recovery is on, RGB is the fill byte repeated in all three channels. When pixel-valid is low and recovery is off, the pixel input passes unchanged.
- R9: The frame pulse is high for exactly the one clock after the frame counter wraps. No pulse comes when starting from the stopped state.
- R10: When the run bit is cleared mid-frame, the frame runs to its end. The pulse is raised at the wrap, and the block then stops.
- R11: While stopped, both counters stay at 0, the syncs sit at their inactive level and data-enable is low. Setting the run bit starts frame position 0 on the following clock.
- R12: Timing fields (addresses 0 to 6) written during a frame do not change that frame. They take effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| pix_valid | input | 1 | Pixel source has data (low = underflow) |
| pix_rgb | input | 24 | Pixel from source, 8 bits per channel |
| hsync | output | 1 | Horizontal sync, polarity per R6 |
| vsync | output | 1 | Vertical sync, polarity per R6 |
| de | output | 1 | Data-enable |
| rgb_out | output | 24 | Output pixel |
| frame_irq | output | 1 | One-clock frame wrap pulse |

## Verification
The hardest state to reach is a stop request that lands in the middle of a frame while the shadow copy holds different timing. The block has to finish the old frame with the old timing, pulse once, and then go quiet. The stimulus programs a random mode, runs whole frames, then writes a longer frame period partway through a frame and later clears the run bit at a random mid-frame position. Every clock is compared with a reference model written from the requirements. Random underflow on the pixel input exercises the fill path both with recovery on and with it off.

// File: rtl/tv_timing_gen.sv
module tv_timing_gen #(
  parameter int HW = 16,
  parameter int FW = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        pix_valid,
  input  logic [23:0] pix_rgb,
  output logic        hsync,
  output logic        vsync,
  output logic        de,
  output logic [23:0] rgb_out,
  output logic        frame_irq
);

  typedef struct packed {
    logic [HW-1:0] hper, hpw, hfirst, hlast, skew;
    logic [FW-1:0] fper, vlen, vfirst, vlast;
  } tmg_t;

  tmg_t sh, act;
  logic [1:0]    pol;
  logic [23:0]   border;
  logic [7:0]    fill;
  logic          rec_en, run_req, running, irq_q;
  logic [HW-1:0] hcnt;
  logic [FW-1:0] fcnt;

  wire frame_end = running && (fcnt == act.fper - FW'(1));
  wire line_end  = (hcnt == act.hper - HW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      pol     <= '0;
      border  <= '0;
      fill    <= 8'hFF;
      rec_en  <= 1'b0;
      run_req <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        4'd0:  begin sh.hper <= reg_wdata[HW-1:0]; sh.hpw <= reg_wdata[16 +: HW]; end
        4'd1:  sh.fper <= reg_wdata[FW-1:0];
        4'd2:  sh.vlen <= reg_wdata[FW-1:0];
        4'd3:  begin sh.hfirst <= reg_wdata[HW-1:0]; sh.hlast <= reg_wdata[16 +: HW]; end
        4'd4:  sh.vfirst <= reg_wdata[FW-1:0];
        4'd5:  sh.vlast <= reg_wdata[FW-1:0];
        4'd6:  sh.skew <= reg_wdata[HW-1:0];
        4'd7:  pol <= reg_wdata[1:0];
        4'd8:  border <= reg_wdata[23:0];
        4'd9:  begin fill <= reg_wdata[7:0]; rec_en <= reg_wdata[8]; end
        4'd10: run_req <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act     <= '0;
      running <= 1'b0;
      hcnt    <= '0;
      fcnt    <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= frame_end;
      if (!running || frame_end) act <= sh;
      if (!running) begin
        running <= run_req;
        hcnt    <= '0;
        fcnt    <= '0;
      end else if (frame_end) begin
        running <= run_req;
        hcnt    <= '0;
        fcnt    <= '0;
      end else begin
        hcnt <= line_end ? '0 : hcnt + HW'(1);
        fcnt <= fcnt + FW'(1);
      end
    end
  end

  wire [HW:0] hs_stop = {1'b0, act.skew} + {1'b0, act.hpw};
  wire hs_on  = running && (hcnt >= act.skew) && ({1'b0, hcnt} < hs_stop);
  wire vs_on  = running && (fcnt < act.vlen);
  wire in_win = (hcnt >= act.hfirst) && (hcnt <= act.hlast) &&
                (fcnt >= act.vfirst) && (fcnt <= act.vlast);

  assign hsync     = hs_on ^ pol[0];
  assign vsync     = vs_on ^ pol[1];
  assign de        = running && in_win;
  assign frame_irq = irq_q;
  assign rgb_out   = !running ? 24'h0 :
                     !in_win  ? border :
                     (pix_valid || !rec_en) ? pix_rgb : {3{fill}};

endmodule

// File: rtl/tv_timing_gen_chk.sv
module tv_timing_gen_chk #(
  parameter int FW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          running,
  input logic [FW-1:0] fcnt,
  input logic [FW-1:0] fper,
  input logic          hsync,
  input logic          pol_h,
  input logic          de,
  input logic          frame_irq
);

  a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq && fper > FW'(1) |=> !frame_irq);

  a_r10_stop_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> frame_irq);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !de && hsync == pol_h);

  a_r4_frame_bound: assert property (@(posedge clk) disable iff (!rst_n)
    running && fper != '0 |-> fcnt < fper);

  a_r12_timing_held: assert property (@(posedge clk) disable iff (!rst_n)
    running && $past(running) && fcnt != '0 |-> $stable(fper));

endmodule

bind tv_timing_gen tv_timing_gen_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .running(running), .fcnt(fcnt), .fper(act.fper),
  .hsync(hsync), .pol_h(pol[0]), .de(de), .frame_irq(frame_irq)
);

// File: tb/tv_timing_gen_bench.sv
module tv_timing_gen_bench;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic pix_valid = 1'b0;
  logic [23:0] pix_rgb = '0;
  logic hsync, vsync, de, frame_irq;
  logic [23:0] rgb_out;

  always #2 clk = ~clk;

  tv_timing_gen u_tv_timing_gen (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pix_valid(pix_valid), .pix_rgb(pix_rgb),
    .hsync(hsync), .vsync(vsync), .de(de), .rgb_out(rgb_out),
    .frame_irq(frame_irq)
  );

  typedef struct {
    int hper, hpw, hfirst, hlast, skew, fper, vlen, vfirst, vlast;
  } cfg_t;

  cfg_t sh, act;
  int pol = 0, border = 0, fill = 8'hFF, rec = 0, en_sh = 0;
  int m_run = 0, m_pos = 0, m_h = 0, m_irq = 0;
  int checks = 0, fails = 0;
  bit done = 0;
  string phase = "";

  function automatic cfg_t zero_cfg();
    cfg_t c;
    c.hper = 0; c.hpw = 0; c.hfirst = 0; c.hlast = 0; c.skew = 0;
    c.fper = 0; c.vlen = 0; c.vfirst = 0; c.vlast = 0;
    return c;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    string t;
    t = (phase != "") ? phase : tag;
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at %0t: got %0h expected %0h (pos %0d col %0d)", t, $time, got, exp, m_pos, m_h);
    end
  endtask

  // register field decoding as listed in R1
  function automatic void apply_write(input int a, input logic [31:0] d);
    case (a)
      0:  begin sh.hper = d[15:0]; sh.hpw = d[31:16]; end
      1:  sh.fper = d;
      2:  sh.vlen = d;
      3:  begin sh.hfirst = d[15:0]; sh.hlast = d[31:16]; end
      4:  sh.vfirst = d;
      5:  sh.vlast = d;
      6:  sh.skew = d[15:0];
      7:  pol = d[1:0];
      8:  border = d[23:0];
      9:  begin fill = d[7:0]; rec = d[8]; end
      10: en_sh = d[0];
      default: ;
    endcase
  endfunction

  task automatic step(input bit we, input int a, input logic [31:0] d);
    logic pv;
    logic [23:0] pr, e_rgb;
    bit win, hs, vs;
    int last;
    pv = ($urandom % 4) != 0;
    pr = 24'($urandom);
    pix_valid = pv; pix_rgb = pr;
    reg_we = we; reg_addr = 4'(a); reg_wdata = d;
    #1;
    hs  = m_run != 0 && m_h >= act.skew && m_h < act.skew + act.hpw;
    vs  = m_run != 0 && m_pos < act.vlen;
    win = m_h >= act.hfirst && m_h <= act.hlast && m_pos >= act.vfirst && m_pos <= act.vlast;
    if (m_run == 0) e_rgb = 24'h0;
    else if (!win) e_rgb = 24'(border);
    else if (pv || rec == 0) e_rgb = pr;
    else e_rgb = {3{8'(fill)}};
    if (m_run == 0) begin
      check("R11", 32'(hsync), 32'(pol & 1));
      check("R11", 32'(vsync), 32'((pol >> 1) & 1));
      check("R11", 32'(de), 0);
      check("R7", 32'(rgb_out), 0);
    end else begin
      check("R3", 32'(hsync), 32'(hs ^ pol[0]));
      check("R4", 32'(vsync), 32'(vs ^ pol[1]));
      check("R5", 32'(de), 32'(win));
      check(win ? "R8" : "R7", 32'(rgb_out), 32'(e_rgb));
    end
    check("R9", 32'(frame_irq), 32'(m_irq));
    @(posedge clk);
    last = (m_run != 0 && m_pos == act.fper - 1) ? 1 : 0;
    m_irq = last;
    if (m_run == 0 || last != 0) act = sh;
    if (m_run == 0) begin m_run = en_sh; m_pos = 0; m_h = 0; end
    else if (last != 0) begin m_run = en_sh; m_pos = 0; m_h = 0; end
    else begin m_pos++; m_h = (m_h == act.hper - 1) ? 0 : m_h + 1; end
    if (we) apply_write(a, d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int ht, hd, hss, hse, vt, vd, vss, vse, skew, stop_at;
    void'($urandom(32'h5eed_0042));
    sh = zero_cfg(); act = zero_cfg();
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2", 32'(hsync), 0);
    check("R2", 32'(vsync), 0);
    check("R2", 32'(de), 0);
    check("R2", 32'(rgb_out), 0);
    check("R2", 32'(frame_irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle(3);

    for (int cfg = 0; cfg < 6; cfg++) begin
      if (cfg == 0) begin
        ht = 12; hd = 8; hss = 8; hse = 10; vt = 4; vd = 3; vss = 3; vse = 4; skew = 0;
      end else begin
        ht = 10 + int'($urandom % 11);
        hd = ht - 4 - int'($urandom % 3);
        hss = hd + 1 + int'($urandom % 2);
        hse = hss + 1 + int'($urandom % (ht - hss - 1));
        vt = 4 + int'($urandom % 4);
        vd = vt - 3;
        vss = vd + 1;
        vse = vss + 1 + int'($urandom % 2);
        skew = int'($urandom % 3);
      end
      // R1: timing fields written through the map, values derived from mode
      step(1, 0, {16'(hse - hss), 16'(ht)});
      step(1, 1, 32'(vt * ht));
      step(1, 2, 32'((vse - vss) * ht));
      step(1, 3, {16'(ht - (hss - hd) - 1), 16'(ht - hss)});
      step(1, 4, 32'((vt - vss) * ht + skew));
      step(1, 5, 32'(vt * ht - (vss - vd) * ht + skew - 1));
      step(1, 6, 32'(skew));
      phase = "R6";
      step(1, 7, (cfg == 1) ? 32'd3 : 32'($urandom % 4));
      idle(2);
      phase = "";
      step(1, 8, 32'($urandom) & 32'hFFFFFF);
      step(1, 9, (cfg == 0) ? 32'h1AB : {23'd0, (cfg % 2 == 0), 8'($urandom)});
      step(1, 10, 1);
      idle(2 * vt * ht + int'($urandom % (vt * ht)));

      if (cfg == 2 || cfg == 4) begin
        phase = "R12";
        step(1, 1, 32'((vt + 1) * ht));
        idle(3 * (vt + 1) * ht);
        phase = "";
      end

      stop_at = 1 + int'($urandom % (act.fper - 2));
      while (m_pos != stop_at) step(0, 0, 0);
      phase = "R10";
      step(1, 10, 0);
      while (m_run != 0) step(0, 0, 0);
      step(0, 0, 0);
      phase = "R11";
      idle(5);
      phase = "";
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule